// File: doc/BRIEF.md
# DMA Read Request Chunk Splitter

This block turns one host-memory read, given as a start address and a byte count, into a series of bus read requests. Each request is no larger than a configured maximum chunk size. Each request also respects an address boundary, so a request never straddles a region that the memory side treats as one burst. The block presents one request at a time on a valid/grant handshake. It counts the requests that have been issued but not yet completed, and it holds back the next request while that count sits at a programmable ceiling. A completion pulse retires one outstanding request.

The configuration is captured when the transfer starts. It selects the maximum chunk size (64, 128 or 256 bytes), turns on an alignment-aware split mode, and sets the pending-read ceiling. In split mode with a 128-byte chunk size, a full 128-byte request goes out only from a 128-byte aligned address. From any other address, requests stop at the next 64-byte line.

The block raises an idle flag whenever no transfer is in progress. It gives a one-cycle done pulse once every byte has been requested and every request has completed. The block moves no data: it only decides request boundaries and issue timing.

Top module: `dma_rd_splitter`

## Requirements
- R1: After reset, `idle` is 1, `req_valid` is 0 and `done` is 0.
- R2: `start` is accepted only while `idle` is 1. `idle` reads 0 from the cycle after an accepted start. A `start` raised while a transfer is running has no effect on the requests of that transfer.
- R3: With split mode off, the size select chooses the maximum chunk: 0 means 64, 1 means 128, and 2 or 3 mean 256 bytes. Each request length is the smallest of the bytes still to request, the maximum chunk, and the distance from the request address to the next multiple of the maximum chunk.
- R4: With split mode on and size select 1, a request issued from a 128-byte aligned address may be up to 128 bytes long.
- R5: With split mode on and size select 1, a request issued from an address that is not 128-byte aligned never crosses a 64-byte boundary.
- R6: Split mode has no effect when the size select is not 1.
- R7: Any byte count is accepted, including counts that are not a multiple of four. The request lengths of one transfer add up exactly to the byte count, and each request address follows on from the end of the one before it.
- R8: While `req_valid` is 1 and `req_grant` is 0, the request stays valid on the next cycle with the same address and length.
- R9: `req_valid` is 0 whenever the number of outstanding requests equals the effective limit, and 1 whenever bytes remain and the count is below that limit. A grant adds one to the count and a `cpl` pulse removes one.
- R10: The effective limit is 1 when the limit field is 0, 12 when the field is above 12, and the field value otherwise.
- R11: `done` is high for exactly one cycle, once no bytes remain and no requests are outstanding. `idle` is 1 on the following cycle.
- R12: A transfer with a byte count of zero issues no request and pulses `done` on the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_addr | input | ADDR_W | Byte address of the first byte |
| start_len | input | LEN_W | Number of bytes to read |
| cfg_size_sel | input | 2 | Maximum chunk: 0=64, 1=128, 2/3=256 bytes |
| cfg_split_en | input | 1 | Alignment-aware split mode |
| cfg_pend_lim | input | 4 | Ceiling on outstanding requests |
| req_valid | output | 1 | A request is offered |
| req_grant | input | 1 | Bus accepts the offered request |
| req_addr | output | ADDR_W | Request byte address |
| req_len | output | 9 | Request length in bytes (1 to 256) |
| cpl | input | 1 | One outstanding request has completed |
| idle | output | 1 | No transfer in progress |
| done | output | 1 | One-cycle pulse at end of transfer |

## Verification
The bench builds the block with a 32-bit address, a 16-bit byte count and a pending ceiling of 12. The 16-bit count allows transfers of twenty chunks and more, which is long enough for a slow completion stream to pile up twelve outstanding requests. That makes it possible to see that a field value of 15 is clamped, and that a field value of 0 still lets one request through. The 32-bit address lets start points sit just below 64-, 128- and 256-byte lines, so every boundary case of the split rule is reached. Pseudo-random grant stalls and sparse completions exercise the request hold and the limit gating.

// File: rtl/dma_split_pkg.sv
// Shared constants and types for the DMA read request splitter.
// Assumes chunk sizes are powers of two between 64 and 256 bytes.
package dma_split_pkg;

    localparam int unsigned BASE_CHUNK  = 64;   // smallest chunk and split line
    localparam int unsigned CHUNK_W     = 9;    // holds lengths up to 256
    localparam int unsigned LIM_FIELD_W = 4;    // width of the pending-limit field

    typedef enum logic [1:0] {
        SZ_64   = 2'd0,
        SZ_128  = 2'd1,
        SZ_256  = 2'd2,
        SZ_256B = 2'd3
    } chunk_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } xfer_state_e;

    typedef struct packed {
        logic [1:0]             size_sel;
        logic                   split_en;
        logic [LIM_FIELD_W-1:0] pend_lim;
    } split_cfg_t;

endpackage

// File: rtl/dma_cfg_decode.sv
// Decodes a captured configuration word into the maximum chunk size,
// the split-mode qualifier and the effective pending-read limit.
// Assumes MAX_PEND fits in CNT_W bits.
module dma_cfg_decode
    import dma_split_pkg::*;
#(
    parameter int unsigned MAX_PEND = 12,
    parameter int unsigned CNT_W    = $clog2(MAX_PEND + 1)
) (
    input  split_cfg_t         cfg,
    output logic [CHUNK_W-1:0] max_bytes,
    output logic               split128,
    output logic [CNT_W-1:0]   lim_eff
);

    // Map the size select onto a byte count.
    always_comb begin
        unique case (cfg.size_sel)
            SZ_64:   max_bytes = CHUNK_W'(BASE_CHUNK);
            SZ_128:  max_bytes = CHUNK_W'(2 * BASE_CHUNK);
            default: max_bytes = CHUNK_W'(4 * BASE_CHUNK);
        endcase
    end

    // Split mode only matters for the 128-byte size.
    always_comb split128 = cfg.split_en && (cfg.size_sel == SZ_128);

    // Clamp the limit field into 1..MAX_PEND.
    always_comb begin
        if (cfg.pend_lim == '0)
            lim_eff = CNT_W'(1);
        else if (32'(cfg.pend_lim) > MAX_PEND)
            lim_eff = CNT_W'(MAX_PEND);
        else
            lim_eff = CNT_W'(cfg.pend_lim);
    end

endmodule

// File: rtl/dma_chunk_calc.sv
// Works out the length of the next request from the low address bits,
// the bytes still to request and the decoded chunk settings.
// Assumes LEN_W > CHUNK_W and that max_bytes is 64, 128 or 256.
module dma_chunk_calc
    import dma_split_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic [7:0]         addr_lo,
    input  logic [LEN_W-1:0]   remain,
    input  logic [CHUNK_W-1:0] max_bytes,
    input  logic               split128,
    output logic [CHUNK_W-1:0] chunk_len
);

    logic [CHUNK_W-1:0] bnd;
    logic [CHUNK_W-1:0] bnd_mask;
    logic [CHUNK_W-1:0] bnd_off;
    logic [CHUNK_W-1:0] to_bnd;

    // Pick the boundary: the 64-byte line when split mode meets an unaligned address.
    always_comb begin
        if (split128 && (addr_lo[6:0] != 7'd0))
            bnd = CHUNK_W'(BASE_CHUNK);
        else
            bnd = max_bytes;
    end

    // Distance from the address to the next boundary.
    always_comb begin
        bnd_mask = bnd - CHUNK_W'(1);
        bnd_off  = {1'b0, addr_lo} & bnd_mask;
        to_bnd   = bnd - bnd_off;
    end

    // Clip the distance by the bytes still to request.
    always_comb begin
        if (LEN_W'(to_bnd) > remain)
            chunk_len = remain[CHUNK_W-1:0];
        else
            chunk_len = to_bnd;
    end

endmodule

// File: rtl/dma_pend_tracker.sv
// Counts requests that were granted but not yet completed and flags when
// the count has reached the effective limit.
// Assumes the caller never issues while at_limit is high.
module dma_pend_tracker #(
    parameter int unsigned MAX_PEND = 12,
    parameter int unsigned CNT_W    = $clog2(MAX_PEND + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             retire,
    input  logic [CNT_W-1:0] lim_eff,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);

    logic retire_ok;

    // A completion with nothing outstanding is dropped.
    always_comb retire_ok = retire && (count != '0);

    // Up/down count of outstanding requests.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else begin
            unique case ({issue, retire_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // Compare against the ceiling.
    always_comb at_limit = (count >= lim_eff);

    AST_PEND_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        count <= lim_eff);                                             // R9
    AST_ISSUE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (count < lim_eff));                                  // R9
    AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !issue && count != '0) |=> (count == $past(count) - CNT_W'(1))); // R9

endmodule

// File: rtl/dma_rd_splitter.sv
// Top of the DMA read request splitter. Captures a transfer on start,
// offers one request at a time, advances on grant and finishes with a
// done pulse when all bytes are requested and all requests completed.
// Assumes ADDR_W >= 8 and LEN_W > 9.
module dma_rd_splitter
    import dma_split_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned LEN_W    = 16,
    parameter int unsigned MAX_PEND = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [LEN_W-1:0]   start_len,
    input  logic [1:0]         cfg_size_sel,
    input  logic               cfg_split_en,
    input  logic [3:0]         cfg_pend_lim,
    output logic               req_valid,
    input  logic               req_grant,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [CHUNK_W-1:0] req_len,
    input  logic               cpl,
    output logic               idle,
    output logic               done
);

    localparam int unsigned CNT_W = $clog2(MAX_PEND + 1);

    xfer_state_e         state_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [LEN_W-1:0]    rem_q;
    split_cfg_t          cfg_q;
    logic                launch;
    logic                fire;
    logic [CHUNK_W-1:0]  max_bytes;
    logic                split128;
    logic [CNT_W-1:0]    lim_eff;
    logic [CHUNK_W-1:0]  chunk_len;
    logic [CNT_W-1:0]    pend_cnt;
    logic                at_limit;

    // Accept a start only between transfers.
    always_comb launch = start && (state_q == ST_IDLE);

    // Transfer state: idle until launch, back to idle on done.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (launch)
            state_q <= ST_RUN;
        else if (done)
            state_q <= ST_IDLE;
    end

    // Capture configuration for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (launch)
            cfg_q <= '{size_sel: cfg_size_sel, split_en: cfg_split_en, pend_lim: cfg_pend_lim};
    end

    // Current address and remaining bytes, advanced by each granted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (launch) begin
            addr_q <= start_addr;
            rem_q  <= start_len;
        end else if (fire) begin
            addr_q <= addr_q + ADDR_W'(chunk_len);
            rem_q  <= rem_q - LEN_W'(chunk_len);
        end
    end

    dma_cfg_decode #(
        .MAX_PEND (MAX_PEND),
        .CNT_W    (CNT_W)
    ) u_cfg (
        .cfg       (cfg_q),
        .max_bytes (max_bytes),
        .split128  (split128),
        .lim_eff   (lim_eff)
    );

    dma_chunk_calc #(
        .LEN_W (LEN_W)
    ) u_calc (
        .addr_lo   (addr_q[7:0]),
        .remain    (rem_q),
        .max_bytes (max_bytes),
        .split128  (split128),
        .chunk_len (chunk_len)
    );

    dma_pend_tracker #(
        .MAX_PEND (MAX_PEND),
        .CNT_W    (CNT_W)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (fire),
        .retire   (cpl),
        .lim_eff  (lim_eff),
        .count    (pend_cnt),
        .at_limit (at_limit)
    );

    // Offer a request while bytes remain and the ceiling allows it.
    always_comb begin
        req_valid = (state_q == ST_RUN) && (rem_q != '0) && !at_limit;
        req_addr  = addr_q;
        req_len   = chunk_len;
        fire      = req_valid && req_grant;
    end

    // Status outputs.
    always_comb begin
        idle = (state_q == ST_IDLE);
        done = (state_q == ST_RUN) && (rem_q == '0) && (pend_cnt == '0);
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!req_valid && !done));                               // R2
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_grant) |=> (req_valid && $stable(req_addr) && $stable(req_len))); // R8
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0 && req_len <= max_bytes));       // R3
    AST_SPLIT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_q.split_en && cfg_q.size_sel == SZ_128 && req_addr[6:0] != 7'd0)
        |-> (({4'd0, req_addr[5:0]} + {1'b0, req_len}) <= 10'd64));   // R5
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (idle && !done));                                     // R11
    AST_LIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_eff != '0) && (32'(lim_eff) <= MAX_PEND));               // R10

endmodule

// File: tb/tb_dma_rd_splitter.sv
`timescale 1ns/1ps
module tb_dma_rd_splitter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] start_addr;
    logic [15:0] start_len;
    logic [1:0]  cfg_size_sel;
    logic        cfg_split_en;
    logic [3:0]  cfg_pend_lim;
    logic        req_valid;
    logic        req_grant;
    logic [31:0] req_addr;
    logic [8:0]  req_len;
    logic        cpl;
    logic        idle;
    logic        done;

    int checks = 0;
    int errors = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    dma_rd_splitter #(.ADDR_W(32), .LEN_W(16), .MAX_PEND(12)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_len(start_len), .cfg_size_sel(cfg_size_sel), .cfg_split_en(cfg_split_en),
        .cfg_pend_lim(cfg_pend_lim), .req_valid(req_valid), .req_grant(req_grant),
        .req_addr(req_addr), .req_len(req_len), .cpl(cpl), .idle(idle), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_len(input longint addr, input longint rem,
                                   input int sel, input bit split);
        int maxb, bnd, tob;
        maxb = (sel == 0) ? 64 : (sel == 1) ? 128 : 256;
        bnd  = (split && maxb == 128 && (addr % 128) != 0) ? 64 : maxb;
        tob  = bnd - int'(addr % bnd);
        return (rem < tob) ? int'(rem) : tob;
    endfunction

    function automatic int eff_lim(input int lim);
        return (lim == 0) ? 1 : (lim > 12) ? 12 : lim;
    endfunction

    // One transfer against the bench model; returns peak outstanding and first length.
    task automatic run_xfer(input string tag, input longint addr, input int len,
                            input int sel, input bit split, input int lim,
                            input int cpl_period, input bit rnd_grant, input bit poke,
                            output int peak, output int first_len);
        longint ea;
        int rem, outst, cyc, sum, el, lim_e, plen;
        bit fin, held, g, c;
        longint paddr;
        ea = addr; rem = len; outst = 0; cyc = 0; sum = 0; fin = 0; held = 0;
        peak = 0; first_len = -1; lim_e = eff_lim(lim); paddr = 0; plen = 0;
        @(negedge clk);
        start = 1'b1; start_addr = addr[31:0]; start_len = len[15:0];
        cfg_size_sel = sel[1:0]; cfg_split_en = split; cfg_pend_lim = lim[3:0];
        @(negedge clk);
        start = 1'b0;
        chk(idle == 1'b0, "R2 idle after start", idle, 0);
        while (!fin && cyc < 20000) begin
            if (held) begin
                chk(req_valid && req_addr == paddr[31:0] && req_len == plen[8:0],
                    "R8 held request", req_addr, paddr);
            end
            if (req_valid) begin
                el = exp_len(ea, rem, sel, split);
                chk(req_addr == ea[31:0], {tag, " addr"}, req_addr, ea);
                chk(int'(req_len) == el, {tag, " len"}, req_len, el);
                chk(outst < lim_e, "R9 valid below limit", outst, lim_e);
                if (first_len < 0) first_len = int'(req_len);
            end else if (rem != 0 && outst < lim_e) begin
                chk(1'b0, "R9 valid expected", 0, 1);
            end
            if (done) begin
                chk(rem == 0 && outst == 0, "R11 done timing", rem + outst, 0);
                chk(sum == len, "R7 byte total", sum, len);
                fin = 1;
            end else if (rem == 0 && outst == 0) begin
                chk(1'b0, "R11 done expected", 0, 1);
            end
            g = rnd_grant ? lfsr[0] : 1'b1;
            c = (outst > 0) && ((cyc % cpl_period) == cpl_period - 1);
            req_grant = g;
            cpl = c;
            if (poke && cyc == 2) begin
                start = 1'b1; start_addr = 32'h0000_0F00; start_len = 16'd7;
                cfg_size_sel = 2'd2; cfg_split_en = 1'b0; cfg_pend_lim = 4'd1;
            end else begin
                start = 1'b0;
            end
            held = req_valid && !g;
            paddr = req_addr; plen = int'(req_len);
            if (req_valid && g) begin
                ea = ea + req_len; rem = rem - int'(req_len);
                sum = sum + int'(req_len); outst++;
            end
            if (c) outst--;
            if (outst > peak) peak = outst;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc++;
            @(negedge clk);
        end
        req_grant = 1'b0; cpl = 1'b0; start = 1'b0;
        if (!fin) chk(1'b0, {tag, " transfer hung"}, cyc, 0);
        chk(idle == 1'b1 && done == 1'b0, "R11 idle after done", idle, 1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; start = 1'b0; req_grant = 1'b0; cpl = 1'b0;
        start_addr = '0; start_len = '0; cfg_size_sel = '0; cfg_split_en = 1'b0; cfg_pend_lim = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle == 1'b1, "R1 idle", idle, 1);
        chk(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
        chk(done == 1'b0, "R1 done", done, 0);
    endtask

    task automatic t_sizes;
        int pk, fl;
        run_xfer("R3 size64", 64'h1000_0010, 200, 0, 1'b0, 4, 2, 1'b0, 1'b0, pk, fl);
        chk(fl == 48, "R3 first chunk to 64 line", fl, 48);
        run_xfer("R3 size128", 64'h40, 300, 1, 1'b0, 4, 2, 1'b0, 1'b0, pk, fl);
        chk(fl == 64, "R3 first chunk to 128 line", fl, 64);
        run_xfer("R3 size256 sel3", 64'h1F0, 600, 3, 1'b0, 4, 2, 1'b0, 1'b0, pk, fl);
        chk(fl == 16, "R3 first chunk to 256 line", fl, 16);
    endtask

    task automatic t_split;
        int pk, fl;
        run_xfer("R4 split aligned", 64'h80, 256, 1, 1'b1, 4, 2, 1'b0, 1'b0, pk, fl);
        chk(fl == 128, "R4 full 128 chunk", fl, 128);
        run_xfer("R5 split unaligned", 64'h23, 250, 1, 1'b1, 4, 2, 1'b0, 1'b0, pk, fl);
        chk(fl == 29, "R5 first chunk stops at 64 line", fl, 29);
        run_xfer("R6 split with 256", 64'h30, 300, 2, 1'b1, 4, 2, 1'b0, 1'b0, pk, fl);
        chk(fl == 208, "R6 split ignored", fl, 208);
    endtask

    task automatic t_odd;
        int pk, fl;
        run_xfer("R7 three bytes", 64'h7, 3, 0, 1'b0, 1, 1, 1'b0, 1'b0, pk, fl);
        chk(fl == 3, "R7 single short chunk", fl, 3);
        run_xfer("R7 odd count", 64'h3, 131, 1, 1'b1, 3, 3, 1'b1, 1'b0, pk, fl);
    endtask

    task automatic t_backpressure;
        int pk, fl;
        run_xfer("R8 random grant", 64'h2_0005, 2000, 2, 1'b0, 6, 4, 1'b1, 1'b0, pk, fl);
    endtask

    task automatic t_limits;
        int pk, fl;
        run_xfer("R9 limit two", 64'h0, 1024, 0, 1'b0, 2, 9, 1'b0, 1'b0, pk, fl);
        chk(pk == 2, "R9 peak outstanding", pk, 2);
        run_xfer("R10 limit zero", 64'h100, 512, 0, 1'b0, 0, 5, 1'b0, 1'b0, pk, fl);
        chk(pk == 1, "R10 zero acts as one", pk, 1);
        run_xfer("R10 limit fifteen", 64'h400, 1280, 0, 1'b0, 15, 30, 1'b0, 1'b0, pk, fl);
        chk(pk == 12, "R10 clamp to twelve", pk, 12);
    endtask

    task automatic t_busy_start;
        int pk, fl;
        run_xfer("R2 start while busy", 64'h5000, 900, 1, 1'b0, 2, 6, 1'b0, 1'b1, pk, fl);
    endtask

    task automatic t_zero_len;
        @(negedge clk);
        start = 1'b1; start_addr = 32'h1234; start_len = 16'd0;
        cfg_size_sel = 2'd0; cfg_split_en = 1'b0; cfg_pend_lim = 4'd4;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R12 done next cycle", done, 1);
        chk(req_valid == 1'b0, "R12 no request", req_valid, 0);
        @(negedge clk);
        chk(idle == 1'b1 && done == 1'b0, "R12 back to idle", idle, 1);
    endtask

    initial begin
        t_reset();
        t_sizes();
        t_split();
        t_odd();
        t_backpressure();
        t_limits();
        t_busy_start();
        t_zero_len();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule